// File: doc/BRIEF.md
# Hall-Sensor Six-Step Commutator with Dead-Time Insertion

This block turns the three Hall sensor lines of a three-phase brushless motor into the six inverter switch commands, three for the high-side switches and three for the low-side switches. The Hall lines first pass through a register synchroniser. The synchronised code is then compared with a registered copy of itself, so that every sector change produces a pulse one clock wide. A six-step table maps each valid Hall code to one high-side and one low-side switch on two different phases, for one direction of rotation.

Each sector change starts a dead-time counter. While the counter runs, an active-low release signal holds back every switch that the new pattern would newly turn on. A switch that the new pattern no longer wants goes off at once, so the two switches in one leg are never driven together. A switch that both the old and the new pattern want stays on without a break. The block assumes a free-running clock and a synchronous active-low reset.

Top module: `hall_commutator`

## Requirements
- R1: While `rst_n` is low at a rising edge, all six switch outputs are 0 after that edge. After reset is released with the Hall lines at 000, the outputs stay 0.
- R2: A change on `hall_in` applied before rising edge 1 does not reach the outputs at edges 1 and 2. Turn-offs caused by the change appear after edge 3.
- R3: The six-step map is given as Hall code `{h2,h1,h0}` → switches on, with phase bit 0 = A, 1 = B, 2 = C: 101 → A high + B low, 100 → A high + C low, 110 → B high + C low, 010 → B high + A low, 011 → C high + A low, 001 → C high + B low.
- R4: At every cycle at most one high-side output and at most one low-side output is 1, and never the high and low switch of the same phase together.
- R5: Hall codes 000 and 111 drive all six outputs to 0 from edge 3 onward and keep them at 0.
- R6: A switch that is on and absent from the new pattern turns off at edge 3, with no dead-time delay.
- R7: A switch that the new pattern newly turns on stays off through edge 3+DEAD_CYCLES and turns on at edge 4+DEAD_CYCLES. This leaves at least DEAD_CYCLES cycles with it off after the turn-off edge.
- R8: A switch present in both the old and the new pattern stays on through the whole change.
- R9: A Hall change that arrives while a dead-time interval is running restarts the interval. Turn-ons are then measured from the later change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising-edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| hall_in | input | 3 | Raw Hall sensor lines `{h2,h1,h0}`, asynchronous to `clk` |
| hi_cmd | output | 3 | High-side switch commands, bit 0 = phase A, 1 = B, 2 = C |
| lo_cmd | output | 3 | Low-side switch commands, bit 0 = phase A, 1 = B, 2 = C |

## Verification
A prompt turn-off and a delayed turn-on can fall in the same cycle. This happens when one switch leaves the pattern at the edge on which a restarted interval, or the end of an earlier one, is deciding about another switch. The bench provokes it by stepping through adjacent sectors, by jumping to non-adjacent sectors, and by applying a second Hall change a few cycles into a running dead time. For each stimulus it predicts three snapshots: the unchanged outputs at edge 2, the old pattern AND the new one at edge 3 and again at edge 3+DEAD_CYCLES, and the full new pattern at edge 4+DEAD_CYCLES. A restarted interval must push the full pattern out to the later change.

// File: rtl/bldc_comm_pkg.sv
// Package: shared types and the six-step map for the Hall commutator.
// Assumes Hall code order {h2,h1,h0} and phase bit order {C,B,A}.
package bldc_comm_pkg;

    typedef logic [2:0] hall_t;

    typedef struct packed {
        logic [2:0] hi;
        logic [2:0] lo;
    } sw_pat_t;

    // Map one Hall code to its switch pattern; invalid codes give all off.
    function automatic sw_pat_t six_step(input hall_t code);
        sw_pat_t p;
        p = '0;
        case (code)
            3'b101:  begin p.hi = 3'b001; p.lo = 3'b010; end
            3'b100:  begin p.hi = 3'b001; p.lo = 3'b100; end
            3'b110:  begin p.hi = 3'b010; p.lo = 3'b100; end
            3'b010:  begin p.hi = 3'b010; p.lo = 3'b001; end
            3'b011:  begin p.hi = 3'b100; p.lo = 3'b001; end
            3'b001:  begin p.hi = 3'b100; p.lo = 3'b010; end
            default: p = '0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/hall_sync_detect.sv
// Module: synchronises the Hall lines through SYNC_STAGES registers and
// flags a sector change with a one-cycle pulse by comparing the synchronised
// code against a registered copy. Assumes SYNC_STAGES >= 1.
module hall_sync_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_raw,
    output logic [2:0] hall_now,
    output logic       change
);
    logic [SYNC_STAGES-1:0][2:0] stg;
    logic [2:0]                  hall_prev;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Capture the raw lines into the first stage.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= hall_raw;
            end
        end else begin : g_next
            // Shift the code one stage further down the synchroniser.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign hall_now = stg[SYNC_STAGES-1];

    // Keep the previous synchronised code for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) hall_prev <= '0;
        else        hall_prev <= hall_now;
    end

    // Flag the cycle in which the synchronised code differs from its copy.
    always_comb change = (hall_now != hall_prev);

    // R2: a flagged change is followed by the copy matching the code seen then.
    a_r2_copy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        change |=> (hall_prev == $past(hall_now)));

endmodule

// File: rtl/commutation_map.sv
// Module: combinational six-step lookup from the synchronised Hall code to
// the wanted switch pattern. Assumes the code has already been synchronised.
module commutation_map
    import bldc_comm_pkg::*;
(
    input  logic [2:0] hall_now,
    output logic [2:0] want_hi,
    output logic [2:0] want_lo
);
    sw_pat_t pat;

    // Look the pattern up through the shared table.
    always_comb begin
        pat     = six_step(hall_now);
        want_hi = pat.hi;
        want_lo = pat.lo;
    end

endmodule

// File: rtl/deadtime_timer.sv
// Module: loads DEAD_CYCLES on every change pulse, counts down to zero and
// drives an active-low release: low only when turn-ons may pass.
// A change during a running interval reloads the count.
module deadtime_timer #(
    parameter int DEAD_CYCLES = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic change,
    output logic release_n
);
    localparam int CW = $clog2(DEAD_CYCLES + 1);

    logic [CW-1:0] cnt;

    // Reload on a change, otherwise count down towards zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (change)     cnt <= CW'(DEAD_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    // Hold turn-ons during the change cycle and while counting.
    always_comb release_n = change || (cnt != '0);

    // R9: the count only ever rises because a change came one cycle earlier.
    a_r9_reload_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt > $past(cnt)) |-> $past(change));

    // R7: without a new change a running count steps down by exactly one.
    a_r7_steady_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0 && !change) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/switch_gate.sv
// Module: registers the six switch commands. Turn-offs pass at once; a
// turn-on passes only while the active-low release is low.
module switch_gate (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       release_n,
    input  logic [5:0] want,
    output logic [5:0] sw_q
);
    // Mask with the wanted pattern while held, follow it when released.
    always_ff @(posedge clk) begin
        if (!rst_n)         sw_q <= '0;
        else if (release_n) sw_q <= sw_q & want;
        else                sw_q <= want;
    end

    // R6: no switch is on that the previous cycle's pattern did not want.
    a_r6_off_prompt: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sw_q & ~$past(want)) == '0));

    // R7: a switch only rises when the release was low the cycle before.
    a_r7_on_waits: assert property (@(posedge clk) disable iff (!rst_n)
        ((sw_q & ~$past(sw_q)) != '0) |-> !$past(release_n));

endmodule

// File: rtl/hall_commutator.sv
// Module: top of the Hall six-step commutator with dead-time insertion.
// Assumes a free-running clk, synchronous active-low reset, and Hall lines
// that may be asynchronous to clk.
module hall_commutator #(
    parameter int SYNC_STAGES = 2,
    parameter int DEAD_CYCLES = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall_in,
    output logic [2:0] hi_cmd,
    output logic [2:0] lo_cmd
);
    logic [2:0] hall_now;
    logic       change;
    logic       release_n;
    logic [2:0] want_hi;
    logic [2:0] want_lo;
    logic [5:0] sw_q;

    hall_sync_detect #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hall_raw (hall_in),
        .hall_now (hall_now),
        .change   (change)
    );

    commutation_map map_i (
        .hall_now (hall_now),
        .want_hi  (want_hi),
        .want_lo  (want_lo)
    );

    deadtime_timer #(.DEAD_CYCLES(DEAD_CYCLES)) dead_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .change    (change),
        .release_n (release_n)
    );

    switch_gate gate_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .release_n (release_n),
        .want      ({want_hi, want_lo}),
        .sw_q      (sw_q)
    );

    assign hi_cmd = sw_q[5:3];
    assign lo_cmd = sw_q[2:0];

    // R4: one switch per side at most, never both switches of one leg.
    a_r4_no_shoot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hi_cmd) && $onehot0(lo_cmd) && ((hi_cmd & lo_cmd) == '0));

    // R5: an invalid synchronised code leaves every switch off next cycle.
    a_r5_invalid_off: assert property (@(posedge clk) disable iff (!rst_n)
        (hall_now == 3'b000 || hall_now == 3'b111) |=> (hi_cmd == '0 && lo_cmd == '0));

endmodule

// File: tb/hall_commutator_tb_top.sv
// Scoreboard bench: the driver task pushes predicted output snapshots tagged
// with a cycle number; the monitor pops and compares them at that cycle.
module hall_commutator_tb_top;
    localparam int DEAD = 25;

    typedef struct {
        int         cyc;
        logic [5:0] sw;
        string      req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = 3'b000;
    logic [2:0] hi_cmd;
    logic [2:0] lo_cmd;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    exp_t q[$];
    logic [5:0] shown = '0;

    hall_commutator #(.SYNC_STAGES(2), .DEAD_CYCLES(DEAD)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hall_in (hall_in),
        .hi_cmd  (hi_cmd),
        .lo_cmd  (lo_cmd)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Bench's own six-step map, {hi,lo} with bit 0 = phase A (R3).
    function automatic logic [5:0] pat(input logic [2:0] h);
        case (h)
            3'b101:  return {3'b001, 3'b010};
            3'b100:  return {3'b001, 3'b100};
            3'b110:  return {3'b010, 3'b100};
            3'b010:  return {3'b010, 3'b001};
            3'b011:  return {3'b100, 3'b001};
            3'b001:  return {3'b100, 3'b010};
            default: return 6'b0;
        endcase
    endfunction

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    // Monitor: compare every prediction due at this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].cyc <= cyc) begin
            exp_t e;
            e = q.pop_front();
            check({hi_cmd, lo_cmd}, e.sw, e.req);
        end
    end

    // Driver: apply a code after edge n and predict edges n+2, n+3, n+3+D, n+4+D.
    task automatic apply(input logic [2:0] code, input int hold, input string req);
        int n;
        logic [5:0] part;
        @(negedge clk);
        n = cyc;
        hall_in = code;
        part = shown & pat(code);
        q.push_back('{n + 2, shown, {"R2 ", req}});
        q.push_back('{n + 3, part, {"R6 R8 ", req}});
        if (hold >= DEAD + 5) begin
            q.push_back('{n + 3 + DEAD, part, {"R7 hold ", req}});
            q.push_back('{n + 4 + DEAD, pat(code), {"R7 R3 ", req}});
            shown = pat(code);
        end else begin
            shown = part;
        end
        repeat (hold - 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check({hi_cmd, lo_cmd}, 6'b0, "R1 in reset");
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check({hi_cmd, lo_cmd}, 6'b0, "R1 after release idle");
        // Forward rotation through all six sectors (R3, R8 via kept switch).
        apply(3'b101, 40, "R3 101");
        apply(3'b100, 40, "R3 100");
        apply(3'b110, 40, "R3 110");
        apply(3'b010, 40, "R3 010");
        apply(3'b011, 40, "R3 011");
        apply(3'b001, 40, "R3 001");
        apply(3'b101, 40, "R3 wrap");
        // Non-adjacent jump: everything off, both new switches delayed.
        apply(3'b010, 40, "R7 jump");
        // Invalid codes (R5).
        apply(3'b111, 40, "R5 111");
        apply(3'b011, 40, "R5 recover");
        apply(3'b000, 40, "R5 000");
        apply(3'b110, 40, "R5 recover2");
        // Retrigger inside a running interval (R9).
        apply(3'b010, 6, "R9 first");
        apply(3'b011, 40, "R9 restart");
        apply(3'b001, 2, "R9 quick");
        apply(3'b101, 40, "R9 quick restart");
        // Reset while switches are on (R1).
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({hi_cmd, lo_cmd}, 6'b0, "R1 mid-run reset");
        hall_in = 3'b000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check({hi_cmd, lo_cmd}, 6'b0, "R1 idle after reset");
        shown = '0;
        apply(3'b100, 40, "R1 restart run");
        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard left=%0d expected=0", q.size());
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule